// File: doc/BRIEF.md
# I2C Event Router for Interrupt and DMA Requests

This block sits beside an I2C controller and turns its transfer-complete pulses into requests for the system. There are three destinations: a CPU interrupt line, a DMA transmit request and a DMA receive request. Each destination has its own enable bit. The controller reports whether it is currently sending or receiving, in either master or slave role. The block uses that direction to pick which DMA request line a transfer event drives.

The CPU interrupt for transfer events comes from a sticky flag, which software clears by writing a one to it. A second interrupt source is optional: when it is enabled, the block raises a level interrupt whenever the bus is idle, which means a STOP condition has been seen. That level stays up until software turns the enable off or a new transfer makes the bus busy again.

Software reaches two words through a small synchronous register port. One word holds the enables and the other holds the status.

Top module: `i2c_evt_router`

## Requirements
- R1: After reset, the enable word reads 4'b0001: only the CPU enable is set. The sticky flag is clear and all three request outputs are low.
- R2: The enable word is at address 0 and can be written and read. Its bits are: bit 0 CPU enable, bit 1 transmit DMA enable, bit 2 receive DMA enable, bit 3 bus-idle enable. Read data appears on `reg_rdata_o` in the cycle after the cycle in which `reg_rd_i` is sampled.
- R3: A transfer event sets the sticky flag, which reads back as bit 0 of the status word at address 1. While the CPU enable is set, `cpu_irq_o` rises one cycle after the flag rises and stays high.
- R4: Writing 1 to status bit 0 clears the flag. Writing 0 leaves the flag unchanged. If a transfer event arrives in the same cycle as the clear, the flag stays set.
- R5: While the CPU enable is clear, the flag still sets but does not drive `cpu_irq_o`. Setting the enable again raises `cpu_irq_o`.
- R6: A transfer event with the transmit DMA enable set and `dir_tx_i` = 1 produces a one-cycle high on `dma_tx_req_o` in the next cycle.
- R7: A transfer event with the receive DMA enable set and `dir_tx_i` = 0 produces a one-cycle high on `dma_rx_req_o` in the next cycle.
- R8: The two DMA request outputs are never high together. No request is raised when its enable is clear or when the direction selects the other channel.
- R9: With the bus-idle enable set and `bus_busy_i` low, `cpu_irq_o` is high one cycle later and stays high. Status bit 1 reads 1 while this idle condition holds.
- R10: The bus-idle interrupt drops when software clears the bus-idle enable or when `bus_busy_i` rises. When the bus goes idle with the bus-idle enable clear, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_xfer_i | input | 1 | One-cycle pulse marking a finished byte transfer |
| bus_busy_i | input | 1 | High while a transaction is in progress on the bus |
| dir_tx_i | input | 1 | 1 while the controller sends data, 0 while it receives |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Word address: 0 selects the enable word, 1 selects the status word |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| cpu_irq_o | output | 1 | CPU interrupt, level |
| dma_tx_req_o | output | 1 | Transmit DMA request strobe |
| dma_rx_req_o | output | 1 | Receive DMA request strobe |

## Verification
The assertions assume that `evt_xfer_i` carries single-cycle pulses. They also assume that `dir_tx_i` is stable whenever a pulse is sampled, and that the register port uses only the two defined addresses. The bench drives every input on the falling clock edge and keeps the direction fixed around each pulse. It releases the event input after exactly one cycle. It only ever addresses words 0 and 1, so each property's premise matches what a controller would present.

// File: rtl/i2c_evt_router_pkg.sv
package i2c_evt_router_pkg;

    // Enable word layout, LSB first: cpu, tx, rx, idle
    typedef struct packed {
        logic idle;
        logic rx;
        logic tx;
        logic cpu;
    } en_t;

    localparam int EN_W = $bits(en_t);
    localparam en_t EN_RESET = '{idle: 1'b0, rx: 1'b0, tx: 1'b0, cpu: 1'b1};

    // DMA channel indices
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;
    localparam int N_CH  = 2;

endpackage

// File: rtl/i2c_evt_regs.sv
module i2c_evt_regs
    import i2c_evt_router_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 4,
    parameter int EN_ADDR   = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              evt_i,
    input  logic              idle_act_i,
    output en_t               en_o,
    output logic              flag_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    typedef struct packed {
        en_t               en;
        logic              flag;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_en, wr_stat, clr_req;

    always_comb begin
        st_d    = st_q;
        wr_en   = wr_i && (addr_i == A_EN);
        wr_stat = wr_i && (addr_i == A_STAT);
        clr_req = wr_stat && wdata_i[0];

        if (wr_en) begin
            st_d.en = en_t'(wdata_i[EN_W-1:0]);
        end

        // set has priority over clear
        if (evt_i) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end

        if (rd_i) begin
            if (addr_i == A_EN) begin
                st_d.rdata = DATA_W'(st_q.en);
            end else if (addr_i == A_STAT) begin
                st_d.rdata = DATA_W'({idle_act_i, st_q.flag});
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= EN_RESET;
            st_q.flag  <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign flag_o  = st_q.flag;
    assign rdata_o = st_q.rdata;

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_i) |-> flag_o); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_o) && !$past(wr_i && addr_i == A_STAT && wdata_i[0])) |-> flag_o); // R4
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i && addr_i == A_STAT && wdata_i[0] && !evt_i) |-> !flag_o); // R4

endmodule

// File: rtl/i2c_evt_dma_steer.sv
module i2c_evt_dma_steer
    import i2c_evt_router_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic            dir_tx_i,
    input  logic [N_CH-1:0] ch_en_i,
    output logic [N_CH-1:0] req_o
);

    logic [N_CH-1:0] req_d, req_q;

    // channel CH_TX follows transmit direction, CH_RX follows receive
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam logic WANT_TX = (ch == CH_TX);
        always_comb begin
            req_d[ch] = evt_i && ch_en_i[ch] && (dir_tx_i == WANT_TX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req_o = req_q;

    AST_REQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(evt_i) |-> (req_o == '0)); // R8
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o != '0) |-> ($past(ch_en_i) & req_o) == req_o); // R8

endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
    import i2c_evt_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  en_t  en_i,
    input  logic flag_i,
    input  logic bus_busy_i,
    output logic idle_act_o,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        idle_act_o = en_i.idle && !bus_busy_i;
        irq_d      = (flag_i && en_i.cpu) || idle_act_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

    AST_IDLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i.idle && !bus_busy_i) |-> irq_o); // R9
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(flag_i && en_i.cpu) && !(en_i.idle && !bus_busy_i)) |-> !irq_o); // R10

endmodule

// File: rtl/i2c_evt_router.sv
module i2c_evt_router
    import i2c_evt_router_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 4,
    parameter int EN_ADDR   = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_xfer_i,
    input  logic              bus_busy_i,
    input  logic              dir_tx_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              cpu_irq_o,
    output logic              dma_tx_req_o,
    output logic              dma_rx_req_o
);

    en_t             en_q;
    logic            flag_q;
    logic            idle_act;
    logic [N_CH-1:0] ch_en;
    logic [N_CH-1:0] dma_req;

    i2c_evt_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .EN_ADDR   (EN_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .rd_i       (reg_rd_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .evt_i      (evt_xfer_i),
        .idle_act_i (idle_act),
        .en_o       (en_q),
        .flag_o     (flag_q),
        .rdata_o    (reg_rdata_o)
    );

    always_comb begin
        ch_en        = '0;
        ch_en[CH_TX] = en_q.tx;
        ch_en[CH_RX] = en_q.rx;
    end

    i2c_evt_dma_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_xfer_i),
        .dir_tx_i (dir_tx_i),
        .ch_en_i  (ch_en),
        .req_o    (dma_req)
    );

    i2c_evt_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_q),
        .flag_i     (flag_q),
        .bus_busy_i (bus_busy_i),
        .idle_act_o (idle_act),
        .irq_o      (cpu_irq_o)
    );

    assign dma_tx_req_o = dma_req[CH_TX];
    assign dma_rx_req_o = dma_req[CH_RX];

    AST_DMA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_tx_req_o, dma_rx_req_o})); // R8
    AST_TX_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req_o |-> $past(evt_xfer_i && dir_tx_i)); // R6
    AST_RX_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req_o |-> $past(evt_xfer_i && !dir_tx_i)); // R7

endmodule

// File: tb/i2c_evt_router_tb.sv
module i2c_evt_router_tb;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_xfer_i = 1'b0;
    logic              bus_busy_i = 1'b1;
    logic              dir_tx_i = 1'b0;
    logic              reg_wr_i = 1'b0;
    logic              reg_rd_i = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              cpu_irq_o, dma_tx_req_o, dma_rx_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_evt_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_xfer_i   (evt_xfer_i),
        .bus_busy_i   (bus_busy_i),
        .dir_tx_i     (dir_tx_i),
        .reg_wr_i     (reg_wr_i),
        .reg_rd_i     (reg_rd_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .cpu_irq_o    (cpu_irq_o),
        .dma_tx_req_o (dma_tx_req_o),
        .dma_rx_req_o (dma_rx_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_rd_i = 1'b1; reg_addr_i = a;
        @(negedge clk);
        reg_rd_i = 1'b0;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic tx);
        @(negedge clk);
        dir_tx_i = tx; evt_xfer_i = 1'b1;
        @(negedge clk);
        evt_xfer_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] d;
        check("R1 irq", cpu_irq_o, 0);
        check("R1 tx", dma_tx_req_o, 0);
        check("R1 rx", dma_rx_req_o, 0);
        rd(0, d); check("R1 enables", d, 4'b0001);
        rd(1, d); check("R1 flag", d[0], 0);
    endtask

    task automatic t_regs;
        logic [DATA_W-1:0] d;
        wr(0, 4'b1010); rd(0, d); check("R2 rw a", d, 4'b1010);
        wr(0, 4'b0101); rd(0, d); check("R2 rw b", d, 4'b0101);
        wr(0, 4'b0001);
    endtask

    task automatic t_flag;
        logic [DATA_W-1:0] d;
        pulse(1'b0);
        check("R3 irq not yet", cpu_irq_o, 0);
        @(negedge clk); check("R3 irq", cpu_irq_o, 1);
        repeat (4) @(negedge clk);
        check("R3 irq held", cpu_irq_o, 1);
        rd(1, d); check("R3 flag read", d[0], 1);
        wr(1, 4'b0000); rd(1, d); check("R4 write0 keeps", d[0], 1);
        wr(1, 4'b0001); rd(1, d); check("R4 w1c", d[0], 0);
        @(negedge clk); check("R4 irq low", cpu_irq_o, 0);
        // clear and event together
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = 1; reg_wdata_i = 4'b0001; evt_xfer_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0; evt_xfer_i = 1'b0;
        rd(1, d); check("R4 set wins", d[0], 1);
        wr(1, 4'b0001);
    endtask

    task automatic t_mask;
        logic [DATA_W-1:0] d;
        wr(0, 4'b0000);
        pulse(1'b1);
        repeat (3) @(negedge clk);
        check("R5 masked irq", cpu_irq_o, 0);
        rd(1, d); check("R5 flag still set", d[0], 1);
        wr(0, 4'b0001);
        @(negedge clk); check("R5 unmask irq", cpu_irq_o, 1);
        wr(1, 4'b0001);
    endtask

    task automatic t_dma;
        wr(0, 4'b0110);
        pulse(1'b1);
        check("R6 tx strobe", dma_tx_req_o, 1);
        check("R8 rx quiet on tx", dma_rx_req_o, 0);
        @(negedge clk); check("R6 tx one cycle", dma_tx_req_o, 0);
        pulse(1'b0);
        check("R7 rx strobe", dma_rx_req_o, 1);
        check("R8 tx quiet on rx", dma_tx_req_o, 0);
        @(negedge clk); check("R7 rx one cycle", dma_rx_req_o, 0);
        wr(0, 4'b0010);
        pulse(1'b0);
        check("R8 rx disabled", dma_rx_req_o, 0);
        check("R8 tx wrong dir", dma_tx_req_o, 0);
        wr(0, 4'b0100);
        pulse(1'b1);
        check("R8 tx disabled", dma_tx_req_o, 0);
        check("R8 rx wrong dir", dma_rx_req_o, 0);
        wr(0, 4'b0001);
        wr(1, 4'b0001);
    endtask

    task automatic t_idle;
        logic [DATA_W-1:0] d;
        // stop with idle enable clear
        @(negedge clk); bus_busy_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 stop alone", cpu_irq_o, 0);
        wr(0, 4'b1001);
        @(negedge clk); check("R9 idle irq", cpu_irq_o, 1);
        repeat (5) @(negedge clk);
        check("R9 idle held", cpu_irq_o, 1);
        rd(1, d); check("R9 idle status", d[1], 1);
        bus_busy_i = 1'b1;
        @(negedge clk); check("R10 busy drops", cpu_irq_o, 0);
        rd(1, d); check("R10 status low", d[1], 0);
        bus_busy_i = 1'b0;
        @(negedge clk); check("R9 idle again", cpu_irq_o, 1);
        wr(0, 4'b0001);
        @(negedge clk); check("R10 enable off drops", cpu_irq_o, 0);
        bus_busy_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_flag();
        t_mask();
        t_dma();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule